// File: doc/BRIEF.md
# Scoreboard Issue Hazard Checker

This block sits in the issue stage of an in-order pipeline that feeds four functional unit classes: integer, add, multiply and divide. It keeps two bit-vectors. One holds a busy bit for each unit. The other holds a write-pending bit for each of the 32 architectural registers. Each cycle it looks at one decoded instruction: the target unit, an optional destination and up to two sources. It then decides, in the same cycle, whether that instruction may dispatch.

A granted instruction with a destination marks that register as pending. A granted instruction bound for a non-pipelined unit marks that unit busy. Each unit reports its writebacks as a valid flag plus a destination index, and these clear pending bits. A non-pipelined unit raises a done strobe to free its busy bit. Source-after-write (RAW) hazards stall the instruction, and so do write-after-write (WAW) hazards. Write-after-read hazards are not tracked, because in-order issue reads operands at issue and cannot produce them.

Top module: `sb_issue_top`

## Requirements
- R1: After reset every busy and pending bit is clear, so the first valid instruction is granted whatever its unit, destination or sources.
- R2: The grant is combinational in the cycle the instruction is presented. `issueUnit` is then one-hot, with bit i set for unit code i (0 integer, 1 add, 2 multiply, 3 divide).
- R3: A grant to a non-pipelined unit (multiply and divide by default) sets that unit's busy bit. Later instructions to that unit stall until `unitDone[i]` is seen. A done strobe frees the unit from the following cycle, so a request in the same cycle as the done strobe still stalls. Other units are unaffected.
- R4: Pipelined units (integer and add by default) never stall for structural reasons. Back-to-back grants to them are allowed.
- R5: An instruction stalls when a source it uses names a register whose pending bit is set. This applies to either source.
- R6: An instruction with a destination stalls when that destination's pending bit is set.
- R7: A grant with a destination sets that register's pending bit. A writeback (`wbValid[u]` with index in `wbDest[u*5 +: 5]`) clears it. A writeback arriving in the same cycle as an instruction counts as already resolved for that instruction's hazard check.
- R8: If a writeback clears a register in the same cycle that a grant sets the same register, the register stays pending.
- R9: An instruction without a destination (`instHasDest` low) never sets a pending bit.
- R10: A source whose use flag is low is ignored, even if its index names a pending register.
- R11: No write-after-read check exists. An instruction may write a register that an earlier, still-executing instruction read.
- R12: With `instValid` low, `issueGrant` is low and `issueUnit` is all zeros. Both are also low whenever the instruction stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| instValid | input | 1 | Decoded instruction present |
| instUnit | input | 2 | Target unit code (0 int, 1 add, 2 mul, 3 div) |
| instHasDest | input | 1 | Instruction writes a register |
| instDest | input | 5 | Destination register index |
| instUseA | input | 1 | First source is read |
| instSrcA | input | 5 | First source register index |
| instUseB | input | 1 | Second source is read |
| instSrcB | input | 5 | Second source register index |
| wbValid | input | 4 | Per-unit writeback valid |
| wbDest | input | 20 | Per-unit writeback register index, unit u at bits u*5 +: 5 |
| unitDone | input | 4 | Per-unit completion strobe for non-pipelined units |
| issueGrant | output | 1 | Instruction dispatches this cycle |
| issueUnit | output | 4 | One-hot selected unit, zero when not granted |

## Verification
The bench builds the block with its defaults: 32 registers, four units, and multiply and divide marked non-pipelined. Both branches of the busy-bit generate are therefore present. The structural stall, the release on the done strobe, and two busy units at once can be driven next to back-to-back grants on the pipelined integer and add units. With 32 registers, each scenario can use its own register indices, so pending state from one scenario does not mask hazards in the next. That separation makes the same-cycle writeback bypass and the set-over-clear collision show up in the grant of the following instruction.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int REG_CNT  = 32;
  localparam int UNIT_CNT = 4;
  localparam int REG_W    = $clog2(REG_CNT);
  localparam int UNIT_W   = $clog2(UNIT_CNT);

  // strobes from the hazard control to the scoreboard state
  typedef struct packed {
    logic                fire;
    logic [UNIT_CNT-1:0] unitSel;
    logic                destSet;
    logic [REG_W-1:0]    destIdx;
  } sbStrobe_t;
endpackage

// File: rtl/sb_state.sv
module sb_state
  import sb_pkg::*;
#(
  parameter logic [UNIT_CNT-1:0] NONPIPE_MASK = 4'b1100
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  sbStrobe_t                 strb,
  input  logic [UNIT_CNT-1:0]       wbValid,
  input  logic [UNIT_CNT*REG_W-1:0] wbDest,
  input  logic [UNIT_CNT-1:0]       unitDone,
  output logic [UNIT_CNT-1:0]       busyQ,
  output logic [REG_CNT-1:0]        pendEff
);
  logic [REG_CNT-1:0] pendQ;
  logic [REG_CNT-1:0] clrMask;
  logic [REG_CNT-1:0] setMask;

  // decode every unit's writeback pair into a clear mask
  always_comb begin
    clrMask = '0;
    for (int u = 0; u < UNIT_CNT; u++) begin
      if (wbValid[u]) clrMask[wbDest[u*REG_W +: REG_W]] = 1'b1;
    end
  end

  assign setMask = strb.destSet ? ({{(REG_CNT-1){1'b0}}, 1'b1} << strb.destIdx) : '0;

  // a writeback in this cycle already resolves the hazard
  assign pendEff = pendQ & ~clrMask;

  always_ff @(posedge clk) begin
    if (!rstN) pendQ <= '0;
    else       pendQ <= pendEff | setMask;   // set dominates clear
  end

  generate
    for (genvar u = 0; u < UNIT_CNT; u++) begin : g_unit
      if (NONPIPE_MASK[u]) begin : g_nonpipe
        always_ff @(posedge clk) begin
          if (!rstN)                              busyQ[u] <= 1'b0;
          else if (strb.fire && strb.unitSel[u])  busyQ[u] <= 1'b1;
          else if (unitDone[u])                   busyQ[u] <= 1'b0;
        end

        p_busy_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
          busyQ[u] && !unitDone[u] |=> busyQ[u]);
        p_busy_set_r3: assert property (@(posedge clk) disable iff (!rstN)
          strb.fire && strb.unitSel[u] |=> busyQ[u]);
      end else begin : g_pipe
        assign busyQ[u] = 1'b0;
      end
    end
  endgenerate

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.destSet |=> pendQ[$past(strb.destIdx)]);

  p_wb_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    wbValid[0] && !(strb.destSet && strb.destIdx == wbDest[REG_W-1:0])
    |=> !pendQ[$past(wbDest[REG_W-1:0])]);
endmodule

// File: rtl/sb_ctrl.sv
module sb_ctrl
  import sb_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                instValid,
  input  logic [UNIT_W-1:0]   instUnit,
  input  logic                instHasDest,
  input  logic [REG_W-1:0]    instDest,
  input  logic                instUseA,
  input  logic [REG_W-1:0]    instSrcA,
  input  logic                instUseB,
  input  logic [REG_W-1:0]    instSrcB,
  input  logic [UNIT_CNT-1:0] busyQ,
  input  logic [REG_CNT-1:0]  pendEff,
  output logic                issueGrant,
  output logic [UNIT_CNT-1:0] issueUnit,
  output sbStrobe_t           strb
);
  logic structHaz, rawHaz, wawHaz;
  logic [UNIT_CNT-1:0] unitOneHot;

  assign unitOneHot = {{(UNIT_CNT-1){1'b0}}, 1'b1} << instUnit;
  assign structHaz  = |(busyQ & unitOneHot);
  assign rawHaz     = (instUseA && pendEff[instSrcA]) || (instUseB && pendEff[instSrcB]);
  assign wawHaz     = instHasDest && pendEff[instDest];

  assign issueGrant = instValid && !structHaz && !rawHaz && !wawHaz;
  assign issueUnit  = issueGrant ? unitOneHot : '0;

  always_comb begin
    strb.fire    = issueGrant;
    strb.unitSel = issueUnit;
    strb.destSet = issueGrant && instHasDest;
    strb.destIdx = instDest;
  end

  p_one_unit_r2: assert property (@(posedge clk) disable iff (!rstN)
    issueGrant |-> $countones(issueUnit) == 1);
  p_raw_stall_r5: assert property (@(posedge clk) disable iff (!rstN)
    instUseA && pendEff[instSrcA] |-> !issueGrant);
  p_waw_stall_r6: assert property (@(posedge clk) disable iff (!rstN)
    instHasDest && pendEff[instDest] |-> !issueGrant);
  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rstN)
    !instValid |-> !issueGrant && issueUnit == '0);
endmodule

// File: rtl/sb_issue_top.sv
module sb_issue_top
  import sb_pkg::*;
#(
  parameter logic [UNIT_CNT-1:0] NONPIPE_MASK = 4'b1100
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      instValid,
  input  logic [UNIT_W-1:0]         instUnit,
  input  logic                      instHasDest,
  input  logic [REG_W-1:0]          instDest,
  input  logic                      instUseA,
  input  logic [REG_W-1:0]          instSrcA,
  input  logic                      instUseB,
  input  logic [REG_W-1:0]          instSrcB,
  input  logic [UNIT_CNT-1:0]       wbValid,
  input  logic [UNIT_CNT*REG_W-1:0] wbDest,
  input  logic [UNIT_CNT-1:0]       unitDone,
  output logic                      issueGrant,
  output logic [UNIT_CNT-1:0]       issueUnit
);
  sbStrobe_t           strb;
  logic [UNIT_CNT-1:0] busyQ;
  logic [REG_CNT-1:0]  pendEff;

  sb_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .instValid(instValid), .instUnit(instUnit),
    .instHasDest(instHasDest), .instDest(instDest),
    .instUseA(instUseA), .instSrcA(instSrcA),
    .instUseB(instUseB), .instSrcB(instSrcB),
    .busyQ(busyQ), .pendEff(pendEff),
    .issueGrant(issueGrant), .issueUnit(issueUnit), .strb(strb)
  );

  sb_state #(.NONPIPE_MASK(NONPIPE_MASK)) u_state (
    .clk(clk), .rstN(rstN), .strb(strb),
    .wbValid(wbValid), .wbDest(wbDest), .unitDone(unitDone),
    .busyQ(busyQ), .pendEff(pendEff)
  );
endmodule

// File: tb/sim_sb_issue_top.sv
`timescale 1ns/1ps
module sim_sb_issue_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic        instValid, instHasDest, instUseA, instUseB;
  logic [1:0]  instUnit;
  logic [4:0]  instDest, instSrcA, instSrcB;
  logic [3:0]  wbValid, unitDone;
  logic [19:0] wbDest;
  logic        issueGrant;
  logic [3:0]  issueUnit;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  sb_issue_top u0 (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instUnit(instUnit),
    .instHasDest(instHasDest), .instDest(instDest), .instUseA(instUseA),
    .instSrcA(instSrcA), .instUseB(instUseB), .instSrcB(instSrcB),
    .wbValid(wbValid), .wbDest(wbDest), .unitDone(unitDone),
    .issueGrant(issueGrant), .issueUnit(issueUnit)
  );

  task automatic clearIn();
    instValid = 0; instUnit = 0; instHasDest = 0; instDest = 0;
    instUseA = 0; instSrcA = 0; instUseB = 0; instSrcB = 0;
    wbValid = 0; wbDest = 0; unitDone = 0;
  endtask

  task automatic drive(input int unit, input bit hasD, input int d,
                       input bit uA, input int sA, input bit uB, input int sB);
    instValid = 1; instUnit = 2'(unit); instHasDest = hasD; instDest = 5'(d);
    instUseA = uA; instSrcA = 5'(sA); instUseB = uB; instSrcB = 5'(sB);
  endtask

  task automatic wbk(input int u, input int r);
    wbValid[u] = 1'b1;
    wbDest[u*5 +: 5] = 5'(r);
  endtask

  // sample combinational outputs mid-cycle, then move to the next negedge
  task automatic chk(input bit expG, input logic [3:0] expU, input string tag);
    #2;
    checks++;
    if (issueGrant !== expG || issueUnit !== expU) begin
      errors++;
      $display("FAIL %s: grant=%b unit=%b expected grant=%b unit=%b",
               tag, issueGrant, issueUnit, expG, expU);
    end
    @(negedge clk);
    clearIn();
  endtask

  task automatic t_reset();
    drive(0, 1, 1, 1, 2, 1, 3); chk(1, 4'b0001, "R1 first grant");
    wbk(0, 1);                  chk(0, 4'b0000, "R12 idle");
  endtask

  task automatic t_raw();
    drive(0, 1, 5, 0, 0, 0, 0);  chk(1, 4'b0001, "R2 int grant");
    drive(1, 1, 20, 1, 5, 0, 0); chk(0, 4'b0000, "R5 srcA pending");
    drive(1, 1, 20, 0, 0, 1, 5); chk(0, 4'b0000, "R5 srcB pending");
    drive(1, 0, 0, 0, 5, 1, 3);  chk(1, 4'b0010, "R10 unused source");
    drive(1, 1, 20, 1, 5, 0, 0); wbk(0, 5); chk(1, 4'b0010, "R7 same-cycle writeback");
    drive(0, 0, 0, 1, 5, 0, 0);  chk(1, 4'b0001, "R7 cleared");
    wbk(1, 20);                  chk(0, 4'b0000, "R12 idle");
  endtask

  task automatic t_waw();
    drive(0, 1, 6, 0, 0, 0, 0); chk(1, 4'b0001, "R6 first writer");
    drive(1, 1, 6, 0, 0, 0, 0); chk(0, 4'b0000, "R6 dest pending");
    wbk(0, 6);                  chk(0, 4'b0000, "R12 idle");
    drive(1, 1, 6, 0, 0, 0, 0); chk(1, 4'b0010, "R6 after clear");
    wbk(1, 6);                  chk(0, 4'b0000, "R12 idle");
  endtask

  task automatic t_setwins();
    drive(1, 1, 7, 0, 0, 0, 0); chk(1, 4'b0010, "R8 first writer");
    drive(0, 1, 7, 0, 0, 0, 0); wbk(1, 7); chk(1, 4'b0001, "R8 collide issue");
    drive(1, 0, 0, 1, 7, 0, 0); chk(0, 4'b0000, "R8 still pending");
    wbk(0, 7);                  chk(0, 4'b0000, "R12 idle");
    drive(1, 0, 0, 1, 7, 0, 0); chk(1, 4'b0010, "R8 released");
  endtask

  task automatic t_nodest();
    drive(0, 0, 8, 0, 0, 0, 0);  chk(1, 4'b0001, "R9 store grant");
    drive(1, 1, 21, 1, 8, 1, 8); chk(1, 4'b0010, "R9 no pending set");
    wbk(1, 21);                  chk(0, 4'b0000, "R12 idle");
  endtask

  task automatic t_struct();
    drive(3, 1, 9, 0, 0, 0, 0);  chk(1, 4'b1000, "R3 div grant");
    drive(3, 0, 0, 0, 0, 0, 0);  chk(0, 4'b0000, "R3 div busy");
    drive(2, 1, 10, 0, 0, 0, 0); chk(1, 4'b0100, "R3 other unit");
    drive(3, 0, 0, 0, 0, 0, 0); unitDone[3] = 1'b1; chk(0, 4'b0000, "R3 done same cycle");
    drive(3, 0, 0, 0, 0, 0, 0);  chk(1, 4'b1000, "R3 after done");
    drive(2, 0, 0, 0, 0, 0, 0);  chk(0, 4'b0000, "R3 mul busy");
    unitDone = 4'b1100; wbk(3, 9); wbk(2, 10); chk(0, 4'b0000, "R12 idle");
    drive(2, 0, 0, 0, 0, 0, 0);  chk(1, 4'b0100, "R3 mul freed");
    unitDone[2] = 1'b1;          chk(0, 4'b0000, "R12 idle");
  endtask

  task automatic t_pipe();
    drive(0, 0, 0, 0, 0, 0, 0); chk(1, 4'b0001, "R4 int 1");
    drive(0, 0, 0, 0, 0, 0, 0); chk(1, 4'b0001, "R4 int 2");
    drive(1, 0, 0, 0, 0, 0, 0); chk(1, 4'b0010, "R4 add 1");
    drive(1, 0, 0, 0, 0, 0, 0); chk(1, 4'b0010, "R4 add 2");
  endtask

  task automatic t_war();
    drive(0, 1, 11, 1, 12, 0, 0); chk(1, 4'b0001, "R11 reader");
    drive(1, 1, 12, 0, 0, 0, 0);  chk(1, 4'b0010, "R11 later writer");
    wbk(0, 11); wbk(1, 12);       chk(0, 4'b0000, "R12 idle");
  endtask

  initial begin
    #(20 * 20000);
    errors++;
    $display("FAIL watchdog: grant=%b unit=%b expected run to end", issueGrant, issueUnit);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    clearIn();
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_raw();
    t_waw();
    t_setwins();
    t_nodest();
    t_struct();
    t_pipe();
    t_war();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule